// File: doc/BRIEF.md
# Magic-Sequence Watchdog Timer

A watchdog that counts cycles of its own clock toward a power-of-two limit and raises a one-cycle reset request if software fails to check in. Software checks in with a two-step key: a fixed first word into one register, then a fixed second word into the next. A wrong word, or the second step arriving without the first, is treated as a fault in its own right and also raises a request. A write to a dedicated register raises a request on demand.

Each request stores a cause code in a register that only the power-on reset clears, so software can find out after the system restart why the restart happened. Once it issues a request, the watchdog returns to the stopped state with its enable bit cleared, ready to be started again. Turning the enable bit off only arms a stop. The counter keeps running until the next correct key sequence, so a runaway program cannot silence the watchdog with one stray write.

Top module: `magic_watchdog`

## Requirements
- R1: With exponent field value d, the first reset request after a start or a restart rises exactly 2^(d+1) clock edges after the edge that started or restarted the count, and the cause code is 1 (expired).
- R2: The configuration register is at offset 0x4. Bit 31 is the enable and bits [4:0] are the exponent d. A read returns these two fields and zero in every other bit. Offsets 0x0 and 0xC read as zero.
- R3: While running, writing 0xABCD1234 to offset 0x8 and then 0x4321DCBA to offset 0xC restarts the count from zero, which postpones the expiry.
- R4: While running, any value other than 0xABCD1234 written to offset 0x8 raises a request on the next edge, with cause code 2 (bad key).
- R5: While running, a write to offset 0xC raises a request with cause code 2 if no correct first key came before it, or if its value is not 0x4321DCBA.
- R6: Clearing the enable bit while running does not stop the count. An expiry can still follow. The watchdog stops only when the next correct key sequence completes.
- R7: Writing a word with bit 0 set to offset 0x0 raises a request on the next edge, with cause code 3 (software request), whether or not the watchdog is enabled. Writing a word with bit 0 clear has no effect.
- R8: Reading offset 0x8 returns the cause code of the last request in bits [2:0]. Only the power-on reset clears it to 0, and it stays unchanged until the next request.
- R9: Each request is a single-cycle pulse. After a request the watchdog is stopped and the enable bit reads back as 0, while the exponent field keeps its value.
- R10: While stopped, writes to the key registers have no effect. They raise no request and leave the cause code unchanged.
- R11: A new exponent written while the watchdog is running takes effect only at the next restart. The expiry in progress keeps the length it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock; also times register writes |
| porRstN | input | 1 | Active-low power-on reset; clears all state including the cause code |
| wrEn | input | 1 | Register write strobe, one write per cycle |
| addr | input | ADDR_W | Byte offset of the register being written or read |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| rstReq | output | 1 | One-cycle reset request pulse |

## Verification
The bench first checks the exact edge on which the expiry pulse appears for exponents 0, 2 and 3, with key sequences spaced close to the limit. A counter that is off by one, or that ignores the restart, would fire early or late there. It clears the enable bit without a following key sequence and expects the expiry anyway, which catches a design that stops at once. It then completes the stop and watches that no pulse follows. It rewrites the exponent in the middle of a count, so a design that applies the new value early would fire after 4 cycles instead of 32. The three bad-key forms, soft-request writes with bit 0 clear and key writes while stopped are each checked through the pulse and through the cause code read back afterwards. A power-on reset is applied in the middle of the run to show that it clears the cause code.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DELAY_W = 5;
  localparam int OFF_SOFT = 'h0;
  localparam int OFF_CFG  = 'h4;
  localparam int OFF_KEY1 = 'h8;
  localparam int OFF_KEY2 = 'hC;
  localparam logic [31:0] KEY_FIRST  = 32'hABCD1234;
  localparam logic [31:0] KEY_SECOND = 32'h4321DCBA;

  typedef enum logic [2:0] {
    CAUSE_POWER  = 3'd0,
    CAUSE_EXPIRE = 3'd1,
    CAUSE_BADKEY = 3'd2,
    CAUSE_SOFT   = 3'd3,
    CAUSE_USER   = 3'd4
  } cause_e;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic               restart;
    logic               run;
    logic [DELAY_W-1:0] delay;
  } cntCtl_t;
endpackage

// File: rtl/wdog_dpath.sv
module wdog_dpath
  import wdog_pkg::*;
(
  input  logic    clk,
  input  logic    porRstN,
  input  cntCtl_t ctl,
  output logic    termHit
);
  localparam int CNT_W = 2 ** DELAY_W;

  logic [CNT_W-1:0]   cnt;
  logic [DELAY_W-1:0] actDelay;
  logic [DELAY_W:0]   shamt;
  logic [CNT_W:0]     lastVal;

  always_comb begin
    shamt   = {1'b0, actDelay} + (DELAY_W + 1)'(1);
    lastVal = ((CNT_W + 1)'(1) << shamt) - (CNT_W + 1)'(1);
    termHit = ctl.run && ({1'b0, cnt} == lastVal);
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      cnt      <= '0;
      actDelay <= '0;
    end else if (ctl.restart) begin
      cnt      <= '0;
      actDelay <= ctl.delay;
    end else if (ctl.run) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wrData,
  input  logic               termHit,
  output cntCtl_t            ctl,
  output logic               cfgEn,
  output logic [DELAY_W-1:0] cfgDelay,
  output logic [2:0]         causeCode,
  output logic               running,
  output logic               rstReq
);
  cause_e cause, nextCause;
  logic   stopPend, armed;
  logic   wrSoft, wrCfg, wrKey1, wrKey2;
  logic   goodKick, badKick, expire, reqNow, startNow;

  always_comb begin
    wrSoft   = wrEn && (addr == ADDR_W'(OFF_SOFT)) && wrData[0];
    wrCfg    = wrEn && (addr == ADDR_W'(OFF_CFG));
    wrKey1   = wrEn && (addr == ADDR_W'(OFF_KEY1));
    wrKey2   = wrEn && (addr == ADDR_W'(OFF_KEY2));
    goodKick = running && wrKey2 && armed && (wrData == KEY_SECOND);
    badKick  = running && ((wrKey1 && (wrData != KEY_FIRST)) || (wrKey2 && !goodKick));
    expire   = termHit && !goodKick;
    reqNow   = wrSoft || badKick || expire;
    startNow = wrCfg && wrData[31] && !running;
    if (wrSoft)       nextCause = CAUSE_SOFT;
    else if (badKick) nextCause = CAUSE_BADKEY;
    else              nextCause = CAUSE_EXPIRE;
    ctl.restart = !running || goodKick || reqNow;
    ctl.run     = running;
    ctl.delay   = wrCfg ? wrData[DELAY_W-1:0] : cfgDelay;
    causeCode   = cause;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      cfgEn    <= 1'b0;
      cfgDelay <= '0;
      running  <= 1'b0;
      stopPend <= 1'b0;
      armed    <= 1'b0;
      rstReq   <= 1'b0;
      cause    <= CAUSE_POWER;
    end else begin
      rstReq <= reqNow;
      if (wrCfg) begin
        cfgEn    <= wrData[31];
        cfgDelay <= wrData[DELAY_W-1:0];
        if (running) stopPend <= !wrData[31];
      end
      if (startNow) running <= 1'b1;
      if (running && wrKey1) armed <= (wrData == KEY_FIRST);
      if (goodKick) begin
        armed <= 1'b0;
        if (stopPend) begin
          running  <= 1'b0;
          stopPend <= 1'b0;
        end
      end
      if (reqNow) begin
        cause    <= nextCause;
        running  <= 1'b0;
        stopPend <= 1'b0;
        armed    <= 1'b0;
        cfgEn    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/magic_watchdog.sv
module magic_watchdog
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              rstReq
);
  cntCtl_t            ctl;
  logic               termHit;
  logic               cfgEn;
  logic [DELAY_W-1:0] cfgDelay;
  logic [2:0]         causeCode;
  logic               running;

  wdog_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .termHit(termHit), .ctl(ctl), .cfgEn(cfgEn), .cfgDelay(cfgDelay),
    .causeCode(causeCode), .running(running), .rstReq(rstReq)
  );

  wdog_dpath u_dpath (
    .clk(clk), .porRstN(porRstN), .ctl(ctl), .termHit(termHit)
  );

  always_comb begin
    if (addr == ADDR_W'(OFF_CFG))
      rdData = {cfgEn, {(31 - DELAY_W){1'b0}}, cfgDelay};
    else if (addr == ADDR_W'(OFF_KEY1))
      rdData = {29'b0, causeCode};
    else
      rdData = '0;
  end
endmodule

// File: rtl/magic_watchdog_chk.sv
module magic_watchdog_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              porRstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic              rstReq,
  input logic              running,
  input logic [2:0]        causeBits,
  input logic              cfgEn
);
  logic softWr, key2Good;
  always_comb begin
    softWr   = wrEn && (addr == ADDR_W'(OFF_SOFT)) && wrData[0];
    key2Good = wrEn && (addr == ADDR_W'(OFF_KEY2)) && (wrData == KEY_SECOND);
  end

  p_soft_req_r7: assert property (@(posedge clk) disable iff (!porRstN)
    softWr |=> (rstReq && causeBits == 3'd3));

  p_bad_key1_r4: assert property (@(posedge clk) disable iff (!porRstN)
    (running && wrEn && addr == ADDR_W'(OFF_KEY1) && wrData != KEY_FIRST)
      |=> (rstReq && causeBits == 3'd2));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!porRstN)
    (!running && !softWr) |=> !rstReq);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!porRstN)
    (rstReq && !softWr) |=> !rstReq);

  p_stopped_after_req_r9: assert property (@(posedge clk) disable iff (!porRstN)
    rstReq |-> (!running && !cfgEn));

  p_cause_hold_r8: assert property (@(posedge clk) disable iff (!porRstN)
    !rstReq |-> $stable(causeBits));

  p_stop_needs_kick_r6: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(running) |-> (rstReq || $past(key2Good)));
endmodule

bind magic_watchdog magic_watchdog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .porRstN(porRstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rstReq(rstReq), .running(running), .causeBits(causeCode), .cfgEn(cfgEn)
);

// File: tb/sim_magic_watchdog.sv
module sim_magic_watchdog;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic        rstReq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int expQ[$];
  string tagQ[$];

  localparam logic [3:0] A_SOFT = 4'h0, A_CFG = 4'h4, A_K1 = 4'h8, A_K2 = 4'hC;
  localparam logic [31:0] K1 = 32'hABCD1234, K2 = 32'h4321DCBA;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  magic_watchdog #(.ADDR_W(4)) u0 (
    .clk(clk), .porRstN(porRstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rstReq(rstReq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    check(rdData == exp, req, rdData, exp);
  endtask

  task automatic expectReq(input int at, input string req);
    expQ.push_back(at);
    tagQ.push_back(req);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic por();
    porRstN = 1'b0;
    idle(2);
    porRstN = 1'b1;
    idle(1);
  endtask

  // monitor: pops expected pulse edges and compares
  always @(negedge clk) begin
    #1;
    if (porRstN && rstReq) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected pulse", 32'(cyc), 32'hFFFFFFFF);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(cyc == e, t, 32'(cyc), 32'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w;
    idle(3);
    porRstN = 1'b1;
    idle(1);
    // reset state
    check(rstReq == 1'b0, "R9 reset rstReq", 32'(rstReq), 0);
    rdChk(A_CFG, 32'h0, "R2 cfg after reset");
    rdChk(A_K1, 32'h0, "R8 cause after power-on");
    rdChk(A_K2, 32'h0, "R2 offset 0xC reads zero");
    rdChk(A_SOFT, 32'h0, "R2 offset 0x0 reads zero");
    // key writes while stopped
    wr(A_K1, 32'h0);
    wr(A_K2, 32'hDEAD);
    idle(5);
    rdChk(A_K1, 32'h0, "R10 cause unchanged when stopped");
    // soft request
    wr(A_SOFT, 32'h2);
    idle(3);
    rdChk(A_K1, 32'h0, "R7 bit0 clear ignored");
    expectReq(cyc + 1, "R7 soft request edge");
    wr(A_SOFT, 32'h1);
    idle(2);
    rdChk(A_K1, 32'h3, "R7 cause soft");
    // expiry with d=2
    wr(A_CFG, 32'h8000_0002);
    expectReq(cyc + 8, "R1 expiry d=2");
    rdChk(A_CFG, 32'h8000_0002, "R2 cfg readback");
    idle(12);
    rdChk(A_K1, 32'h1, "R1 cause expired");
    rdChk(A_CFG, 32'h0000_0002, "R9 enable cleared after request");
    // d=0
    wr(A_CFG, 32'h8000_0000);
    expectReq(cyc + 2, "R1 expiry d=0");
    idle(4);
    // keep-alive d=3
    wr(A_CFG, 32'h8000_0003);
    idle(10);
    wr(A_K1, K1);
    wr(A_K2, K2);
    idle(10);
    wr(A_K1, K1);
    wr(A_K2, K2);
    expectReq(cyc + 16, "R3 expiry after keep-alive");
    idle(20);
    rdChk(A_K1, 32'h1, "R3 cause after final expiry");
    // bad first key
    wr(A_CFG, 32'h8000_0005);
    idle(3);
    expectReq(cyc + 1, "R4 wrong first key");
    wr(A_K1, 32'h1234_5678);
    idle(2);
    rdChk(A_K1, 32'h2, "R4 cause bad key");
    // power-on clears cause
    por();
    rdChk(A_K1, 32'h0, "R8 power-on clears cause");
    // second key without first
    wr(A_CFG, 32'h8000_0005);
    idle(2);
    expectReq(cyc + 1, "R5 second key without first");
    wr(A_K2, K2);
    idle(2);
    rdChk(A_K1, 32'h2, "R5 cause unarmed second key");
    por();
    // wrong second key
    wr(A_CFG, 32'h8000_0005);
    wr(A_K1, K1);
    expectReq(cyc + 1, "R5 wrong second key");
    wr(A_K2, 32'h4321DCBB);
    idle(2);
    rdChk(A_K1, 32'h2, "R5 cause wrong second key");
    // disable without kick: still expires
    wr(A_CFG, 32'h8000_0003);
    w = cyc;
    expectReq(w + 16, "R6 disable alone does not stop");
    idle(3);
    wr(A_CFG, 32'h0000_0003);
    idle(20);
    rdChk(A_K1, 32'h1, "R6 cause expired after disable");
    // disable then kick: stops
    wr(A_CFG, 32'h8000_0003);
    idle(3);
    wr(A_CFG, 32'h0000_0003);
    wr(A_K1, K1);
    wr(A_K2, K2);
    idle(40);
    rdChk(A_CFG, 32'h0000_0003, "R6 stopped cfg");
    wr(A_K1, 32'h5);
    idle(3);
    rdChk(A_K1, 32'h1, "R10 bad key ignored once stopped");
    // exponent change mid-count
    wr(A_CFG, 32'h8000_0004);
    w = cyc;
    expectReq(w + 32, "R11 old exponent kept");
    idle(2);
    wr(A_CFG, 32'h8000_0001);
    idle(40);
    wr(A_CFG, 32'h8000_0004);
    idle(2);
    wr(A_CFG, 32'h8000_0001);
    idle(2);
    wr(A_K1, K1);
    wr(A_K2, K2);
    expectReq(cyc + 4, "R11 new exponent after restart");
    idle(8);
    check(expQ.size() == 0, "R9 all expected pulses seen", 32'(expQ.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule